// File: doc/BRIEF.md
# Interrupt Enable and Acceptance Controller

This block sits beside the decoder of an 8-bit-style CPU core. It keeps the interrupt-enable state and the maskable-interrupt mode. At every instruction boundary it decides whether the core takes a non-maskable interrupt, takes a maskable interrupt, or does neither. Two enable bits are held. The primary bit gates maskable requests. The shadow bit preserves the primary bit across a non-maskable service routine, so that the return-from-NMI strobe can put it back.

The decoder sends one-cycle strobes for the enable, disable, return-from-NMI and mode-select instructions, and for the reads of the interrupt and refresh registers into the accumulator. It also sends a strobe in the cycle that closes each instruction. The non-maskable line is synchronised and edge-detected, and the edge is latched until a boundary accepts it. The maskable line is a level.

All results are registered. Each one appears on the cycle after the strobe that causes it. The results are the accept pulses, the restart address, a request to run an acknowledge cycle in mode 0, a request for a vector-table fetch in mode 2, and the shadow-bit value that the datapath copies into parity.

Top module: `irq_gate`

## Requirements
- R1: After a synchronous reset both enable bits are clear and the mode is 0. All accept, vector and request outputs are low, and a maskable request at a boundary is refused.
- R2: The enable strobe sets both bits. The boundary that carries the enable strobe never accepts a maskable request. The same holds for the first boundary after an enable strobe that arrived mid-instruction. The next boundary after that may accept.
- R3: The disable strobe clears both bits, and a boundary in the same cycle does not accept a maskable request.
- R4: Accepting a maskable request clears both enable bits.
- R5: Accepting a non-maskable request clears the primary bit and leaves the shadow bit unchanged.
- R6: The return-from-NMI strobe copies the shadow bit into the primary bit.
- R7: One cycle after the register-read strobe, `par_out` equals the shadow bit as it stood in the strobe cycle. It then holds that value until the next read strobe.
- R8: A rising edge on `nmi_req` is latched until a boundary takes it, whatever the enable bits are. The accept gives `take_nmi` and `vec_valid` high, with `vec_addr` = 0x0066.
- R9: When a non-maskable and a maskable request both qualify at the same boundary, only the non-maskable one is taken.
- R10: In mode 0, a maskable accept raises `take_irq` and `ack_cycle`, with `vec_valid` low.
- R11: In mode 1, a maskable accept raises `take_irq` and `vec_valid`, with `vec_addr` = 0x0038.
- R12: In mode 2, a maskable accept raises `take_irq` and `tbl_fetch`, with `vec_valid` low.
- R13: The mode-select strobe loads `op_im_val` codes 0, 1 and 2 as modes 0, 1 and 2. Code 3 is ignored and the mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_end | input | 1 | Strobe in the last cycle of each instruction |
| op_ei | input | 1 | Enable-interrupts instruction strobe |
| op_di | input | 1 | Disable-interrupts instruction strobe |
| op_retn | input | 1 | Return-from-NMI instruction strobe |
| op_im | input | 1 | Mode-select instruction strobe |
| op_im_val | input | 2 | Mode code carried with `op_im` |
| op_rd_ir | input | 1 | Interrupt/refresh register read strobe |
| nmi_req | input | 1 | Non-maskable request line (edge sensitive) |
| irq_req | input | 1 | Maskable request level |
| take_nmi | output | 1 | Non-maskable accept pulse |
| take_irq | output | 1 | Maskable accept pulse |
| vec_valid | output | 1 | `vec_addr` holds a restart address |
| vec_addr | output | 16 | Restart address, zero when not valid |
| ack_cycle | output | 1 | Request for a mode-0 acknowledge cycle |
| tbl_fetch | output | 1 | Request for a mode-2 vector-table fetch |
| par_out | output | 1 | Shadow-bit value for the parity flag |

## Verification
Every output is one register away from its cause. An accept pulse, vector or request shows on the cycle after the boundary strobe, and `par_out` shows on the cycle after the read strobe. The driver applies one cycle of strobes just after a falling edge and queues the outputs it expects for the next rising edge. The monitor samples 2 ns after that rising edge, so each comparison matches exactly one driven cycle. A non-maskable edge passes two synchroniser stages and the edge register before it is pending. The bench therefore leaves at least two idle cycles between the pulse and the boundary that should take it, and it checks that the idle cycles produce no pulse.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  typedef enum logic [1:0] {
    IMODE_0   = 2'd0,
    IMODE_1   = 2'd1,
    IMODE_2   = 2'd2,
    IMODE_RSV = 2'd3
  } imode_e;
endpackage

// File: rtl/irqg_nmi_edge.sv
module irqg_nmi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic take,
  output logic pend
);
  logic lvl;
  logic lvl_d;
  logic rise;
  logic pend_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign lvl = nmi_in;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_in};
      end
      assign lvl = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;

  // a fresh edge wins over the accept of the previous one
  always_ff @(posedge clk) begin
    if (rst)       pend_q <= 1'b0;
    else if (rise) pend_q <= 1'b1;
    else if (take) pend_q <= 1'b0;
  end

  assign pend = pend_q;

  // R8
  nmi_latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !take) |=> pend_q);
endmodule

// File: rtl/irqg_flags.sv
module irqg_flags
  import irqg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       insn_end,
  input  logic       op_ei,
  input  logic       op_di,
  input  logic       op_retn,
  input  logic       op_im,
  input  logic [1:0] op_im_val,
  input  logic       op_rd_ir,
  input  logic       acc_nmi,
  input  logic       acc_irq,
  output logic       ief_pri,
  output logic       ei_block,
  output imode_e     mode,
  output logic       par_out
);
  logic   pri_q, shd_q, hold_q, par_q;
  logic   pri_n, shd_n;
  imode_e mode_q;

  always_comb begin
    pri_n = pri_q;
    shd_n = shd_q;
    if (op_retn) pri_n = shd_q;
    if (op_ei) begin
      pri_n = 1'b1;
      shd_n = 1'b1;
    end
    if (op_di) begin
      pri_n = 1'b0;
      shd_n = 1'b0;
    end
    if (acc_irq) begin
      pri_n = 1'b0;
      shd_n = 1'b0;
    end else if (acc_nmi) begin
      pri_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= 1'b0;
      shd_q <= 1'b0;
    end else begin
      pri_q <= pri_n;
      shd_q <= shd_n;
    end
  end

  // an enable seen before its own boundary keeps that boundary closed
  always_ff @(posedge clk) begin
    if (rst)                    hold_q <= 1'b0;
    else if (op_ei & ~insn_end) hold_q <= 1'b1;
    else if (insn_end)          hold_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                                       mode_q <= IMODE_0;
    else if (op_im && op_im_val != 2'(IMODE_RSV))  mode_q <= imode_e'(op_im_val);
  end

  always_ff @(posedge clk) begin
    if (rst)           par_q <= 1'b0;
    else if (op_rd_ir) par_q <= shd_q;
  end

  assign ief_pri  = pri_q;
  assign ei_block = op_ei | hold_q;
  assign mode     = mode_q;
  assign par_out  = par_q;

  // R4
  irq_clr_both_chk: assert property (@(posedge clk) disable iff (rst)
    acc_irq |=> (!pri_q && !shd_q));
  // R3
  di_clr_both_chk: assert property (@(posedge clk) disable iff (rst)
    op_di |=> (!pri_q && !shd_q));
  // R5
  nmi_keep_shadow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_nmi && !acc_irq && !op_ei && !op_di) |=> (!pri_q && shd_q == $past(shd_q)));
  // R13
  im_rsv_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (op_im && op_im_val == 2'd3) |=> (mode_q == $past(mode_q)));
  // R13
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q != IMODE_RSV);
endmodule

// File: rtl/irqg_accept.sv
module irqg_accept
  import irqg_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 'h0066,
  parameter logic [ADDR_W-1:0] IM1_VEC = 'h0038
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_end,
  input  logic              nmi_pend,
  input  logic              irq_req,
  input  logic              ief_pri,
  input  logic              ei_block,
  input  logic              op_di,
  input  imode_e            mode,
  output logic              nmi_go,
  output logic              irq_go,
  output logic              take_nmi,
  output logic              take_irq,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              ack_cycle,
  output logic              tbl_fetch
);
  logic              tn_q, ti_q, vv_q, ack_q, tbl_q;
  logic [ADDR_W-1:0] vec_q;

  assign nmi_go = insn_end & nmi_pend;
  assign irq_go = insn_end & irq_req & ief_pri & ~ei_block & ~op_di & ~nmi_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      tn_q  <= 1'b0;
      ti_q  <= 1'b0;
      vv_q  <= 1'b0;
      vec_q <= '0;
      ack_q <= 1'b0;
      tbl_q <= 1'b0;
    end else begin
      tn_q  <= nmi_go;
      ti_q  <= irq_go;
      ack_q <= irq_go && (mode == IMODE_0);
      tbl_q <= irq_go && (mode == IMODE_2);
      if (nmi_go) begin
        vv_q  <= 1'b1;
        vec_q <= NMI_VEC;
      end else if (irq_go && mode == IMODE_1) begin
        vv_q  <= 1'b1;
        vec_q <= IM1_VEC;
      end else begin
        vv_q  <= 1'b0;
        vec_q <= '0;
      end
    end
  end

  assign take_nmi  = tn_q;
  assign take_irq  = ti_q;
  assign vec_valid = vv_q;
  assign vec_addr  = vec_q;
  assign ack_cycle = ack_q;
  assign tbl_fetch = tbl_q;

  // R9
  nmi_first_chk: assert property (@(posedge clk) disable iff (rst)
    !(tn_q && ti_q));
  // R2
  ei_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ei_block |=> !ti_q);
  // R10
  irq_route_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_q, tbl_q, vv_q}));
  // R8
  nmi_vec_chk: assert property (@(posedge clk) disable iff (rst)
    tn_q |-> (vv_q && vec_q == NMI_VEC));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irqg_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] NMI_VEC     = 'h0066,
  parameter logic [ADDR_W-1:0] IM1_VEC     = 'h0038
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_end,
  input  logic              op_ei,
  input  logic              op_di,
  input  logic              op_retn,
  input  logic              op_im,
  input  logic [1:0]        op_im_val,
  input  logic              op_rd_ir,
  input  logic              nmi_req,
  input  logic              irq_req,
  output logic              take_nmi,
  output logic              take_irq,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              ack_cycle,
  output logic              tbl_fetch,
  output logic              par_out
);
  logic   nmi_pend, nmi_go, irq_go, ief_pri, ei_block;
  imode_e mode;

  irqg_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .nmi_in (nmi_req),
    .take   (nmi_go),
    .pend   (nmi_pend)
  );

  irqg_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .insn_end  (insn_end),
    .op_ei     (op_ei),
    .op_di     (op_di),
    .op_retn   (op_retn),
    .op_im     (op_im),
    .op_im_val (op_im_val),
    .op_rd_ir  (op_rd_ir),
    .acc_nmi   (nmi_go),
    .acc_irq   (irq_go),
    .ief_pri   (ief_pri),
    .ei_block  (ei_block),
    .mode      (mode),
    .par_out   (par_out)
  );

  irqg_accept #(
    .ADDR_W  (ADDR_W),
    .NMI_VEC (NMI_VEC),
    .IM1_VEC (IM1_VEC)
  ) u_accept (
    .clk       (clk),
    .rst       (rst),
    .insn_end  (insn_end),
    .nmi_pend  (nmi_pend),
    .irq_req   (irq_req),
    .ief_pri   (ief_pri),
    .ei_block  (ei_block),
    .op_di     (op_di),
    .mode      (mode),
    .nmi_go    (nmi_go),
    .irq_go    (irq_go),
    .take_nmi  (take_nmi),
    .take_irq  (take_irq),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .ack_cycle (ack_cycle),
    .tbl_fetch (tbl_fetch)
  );
endmodule

// File: tb/irq_gate_bench.sv
`timescale 1ns/1ps
module irq_gate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_end = 0, op_ei = 0, op_di = 0, op_retn = 0, op_im = 0, op_rd_ir = 0;
  logic [1:0]  op_im_val = 2'd0;
  logic        nmi_req = 0, irq_req = 0;
  logic        take_nmi, take_irq, vec_valid, ack_cycle, tbl_fetch, par_out;
  logic [15:0] vec_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic        tn, ti, vv, ack, tbl, cp, par;
    logic [15:0] v;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  irq_gate u_irq_gate (
    .clk(clk), .rst(rst), .insn_end(insn_end), .op_ei(op_ei), .op_di(op_di),
    .op_retn(op_retn), .op_im(op_im), .op_im_val(op_im_val), .op_rd_ir(op_rd_ir),
    .nmi_req(nmi_req), .irq_req(irq_req), .take_nmi(take_nmi), .take_irq(take_irq),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .ack_cycle(ack_cycle),
    .tbl_fetch(tbl_fetch), .par_out(par_out)
  );

  function automatic exp_t mk(logic tn, logic ti, logic vv, logic [15:0] v,
                              logic ack, logic tbl, string tag);
    exp_t e;
    e.tn = tn; e.ti = ti; e.vv = vv; e.v = v; e.ack = ack; e.tbl = tbl;
    e.cp = 1'b0; e.par = 1'b0; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t none(string tag);
    return mk(0, 0, 0, 16'h0, 0, 0, tag);
  endfunction

  function automatic exp_t parx(logic p, string tag);
    exp_t e;
    e = none(tag);
    e.cp = 1'b1; e.par = p;
    return e;
  endfunction

  // driver: inputs were set just after a falling edge; queue the result due
  // at the next rising edge, then clear the one-cycle strobes
  task automatic step(input exp_t e);
    sb_q.push_back(e);
    @(negedge clk);
    insn_end = 0; op_ei = 0; op_di = 0; op_retn = 0; op_im = 0; op_rd_ir = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(none(tag));
  endtask

  // monitor: sample 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (take_nmi !== e.tn || take_irq !== e.ti || vec_valid !== e.vv ||
            vec_addr !== e.v || ack_cycle !== e.ack || tbl_fetch !== e.tbl ||
            (e.cp && par_out !== e.par)) begin
          errors++;
          $display("FAIL %s: got tn=%b ti=%b vv=%b v=%h ack=%b tbl=%b par=%b exp tn=%b ti=%b vv=%b v=%h ack=%b tbl=%b par=%b",
                   e.tag, take_nmi, take_irq, vec_valid, vec_addr, ack_cycle, tbl_fetch, par_out,
                   e.tn, e.ti, e.vv, e.v, e.ack, e.tbl, e.cp ? e.par : par_out);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; step(none("R1 reset")); step(none("R1 reset"));
    rst = 0;
    op_rd_ir = 1; step(parx(0, "R1 shadow clear"));
    irq_req = 1; insn_end = 1; step(none("R1 refused when disabled"));

    // mode 0, EI on its own boundary
    op_ei = 1; insn_end = 1; step(none("R2 EI boundary closed"));
    op_rd_ir = 1; step(parx(1, "R7 shadow after EI"));
    insn_end = 1; step(mk(0, 1, 0, 16'h0, 1, 0, "R10 mode0 ack"));
    insn_end = 1; step(none("R4 flags cleared by accept"));
    op_rd_ir = 1; step(parx(0, "R4 shadow cleared"));

    // mode 1, EI strobe before its boundary
    op_im = 1; op_im_val = 2'd1; step(none("R13 select mode1"));
    op_ei = 1; step(none("R2 EI mid-instruction"));
    insn_end = 1; step(none("R2 held boundary closed"));
    insn_end = 1; step(mk(0, 1, 1, 16'h0038, 0, 0, "R11 mode1 vector"));

    // DI
    op_ei = 1; insn_end = 1; step(none("R2 EI boundary"));
    op_di = 1; insn_end = 1; step(none("R3 DI boundary closed"));
    insn_end = 1; step(none("R3 stays disabled"));
    op_rd_ir = 1; step(parx(0, "R3 shadow cleared"));

    // NMI save / restore
    irq_req = 0;
    op_ei = 1; insn_end = 1; step(none("R2 EI"));
    nmi_req = 1; step(none("R8 pulse"));
    nmi_req = 0; idle(4, "R8 latched no boundary");
    insn_end = 1; step(mk(1, 0, 1, 16'h0066, 0, 0, "R8 nmi vector"));
    op_rd_ir = 1; step(parx(1, "R5 shadow kept"));
    irq_req = 1; insn_end = 1; step(none("R5 primary cleared"));
    op_retn = 1; step(none("R6 retn"));
    insn_end = 1; step(mk(0, 1, 1, 16'h0038, 0, 0, "R6 restored accept"));

    // priority
    op_ei = 1; insn_end = 1; step(none("R2 EI"));
    nmi_req = 1; step(none("R9 pulse"));
    nmi_req = 0; idle(3, "R9 wait");
    insn_end = 1; step(mk(1, 0, 1, 16'h0066, 0, 0, "R9 nmi over irq"));

    // mode 2
    op_im = 1; op_im_val = 2'd2; step(none("R13 select mode2"));
    op_retn = 1; step(none("R6 retn"));
    insn_end = 1; step(mk(0, 1, 0, 16'h0, 0, 1, "R12 table fetch"));

    // reserved code
    op_im = 1; op_im_val = 2'd3; step(none("R13 code3"));
    op_ei = 1; insn_end = 1; step(none("R2 EI"));
    insn_end = 1; step(mk(0, 1, 0, 16'h0, 0, 1, "R13 mode kept at 2"));

    // NMI while disabled
    irq_req = 0;
    op_di = 1; step(none("R3 DI"));
    nmi_req = 1; step(none("R8 pulse"));
    nmi_req = 0; idle(3, "R8 wait");
    insn_end = 1; step(mk(1, 0, 1, 16'h0066, 0, 0, "R8 taken when disabled"));
    idle(2, "R8 single pulse");

    @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule